// File: doc/BRIEF.md
# Parallel Configuration Loader

This block lets a host load a downstream programmable device over a byte-wide configuration port. On reset, or when the host pulses a start request, it pulls the device's active-low program line low for a fixed number of cycles. It then releases the line and waits for the device to raise its active-low init line, which shows that the device has cleared its configuration memory. After that it sends one dummy clock with all-ones data, so that a clock edge comes before the first real byte. The host then writes configuration bytes through a strobe, one byte each time the ready flag is high. The loader can reverse the bit order of each byte.

Each byte is placed on the data outputs for one period of a configuration clock. That clock is the system clock divided by a parameter, and the data is held for the whole low half before the rising edge. After the byte the host marks as last, the loader sends a fixed number of trailing all-ones clocks. It then keeps clocking until the device raises done. If the device never raises done, the loader stops after a bounded number of extra periods and reports an error. If init falls while the load is in progress, the loader aborts it. Every fault is reported in a sticky status flag, and the next start request clears all of them.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and after each `host_start` pulse, `cfg_prog_n` is held low for exactly PROG_LOW system cycles (default 16) and is then released. `stat_busy` is high during this time and `stat_rdy` is low.
- R2: After `cfg_prog_n` is released, no configuration clock edge is issued while `cfg_init_n` stays low. If `cfg_init_n` is still low after INIT_TIMEOUT cycles (default 256), `stat_err_init` is set and `stat_busy` falls.
- R3: Once `cfg_init_n` is high, the first rising edge of `cfg_cclk` carries the dummy byte 8'hFF on `cfg_data`, and it comes before any host byte.
- R4: Each `cfg_cclk` period spans CLK_DIV system cycles (default 4). The clock is low for the first CLK_DIV/2 cycles and high for the rest, and `cfg_data` never changes in the cycle in which `cfg_cclk` rises.
- R5: `stat_rdy` is high only in the data phase while the one-byte holding register is empty. Each accepted write produces exactly one `cfg_cclk` rising edge that carries that byte, and the bytes go out in the order they were written.
- R6: When `host_rev` is 1 during a write, the byte is sent with its bits reversed (`cfg_data[7-i]` = `host_data[i]`). When `host_rev` is 0, the byte is sent unchanged.
- R7: A write while `stat_rdy` is low is dropped and no configuration clock edge carries it. It also sets the sticky flag `stat_overrun`.
- R8: After the byte written with `host_last` = 1, the loader sends at least TRAIL_CLKS (default 5) further `cfg_cclk` periods with `cfg_data` = 8'hFF.
- R9: After the trailing periods, clocking continues one period at a time until `cfg_done` is seen high at the end of a period. At that point `stat_done` is set, `stat_busy` falls and `cfg_cclk` stops.
- R10: If `cfg_done` is still low after DONE_TIMEOUT further periods (default 32), `stat_err_done` is set, `stat_busy` falls and clocking stops.
- R11: If `cfg_init_n` goes low at any point from the dummy clock through the done wait, the load is aborted. `stat_err_crc` is set, `stat_busy` and `stat_rdy` fall, and no further clock edges follow.
- R12: A `host_start` pulse clears `stat_done`, all error flags and `stat_overrun`, and begins the R1 sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a power-up load sequence |
| host_start | input | 1 | One-cycle request to reconfigure the device |
| host_wr | input | 1 | Byte write strobe |
| host_data | input | 8 | Configuration byte |
| host_rev | input | 1 | Reverse the bit order of this byte |
| host_last | input | 1 | Marks this byte as the final one |
| stat_busy | output | 1 | A load sequence is in progress |
| stat_rdy | output | 1 | Holding register can take a byte |
| stat_done | output | 1 | Device reported done |
| stat_err_init | output | 1 | Init did not rise in time |
| stat_err_crc | output | 1 | Init fell during the load |
| stat_err_done | output | 1 | Done did not rise in time |
| stat_overrun | output | 1 | A write arrived while not ready |
| cfg_prog_n | output | 1 | Active-low program line to the device |
| cfg_init_n | input | 1 | Active-low init line from the device |
| cfg_done | input | 1 | Done line from the device |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_data | output | 8 | Configuration data byte |

## Verification
The program-low width can be seen on the cycle after reset is released. The bench counts its low samples from that point and expects exactly PROG_LOW. Every configuration clock edge is captured with its data at the falling system edge right after `cfg_cclk` rises, so the checks work on edge order and not on absolute cycle numbers. The done input is raised in the same half cycle as a chosen captured edge, and the loader looks at it at the end of that period. That is why the expected edge totals are exact: 1 + bytes + 5 with done already high, the raising edge's index when done comes late, and 1 + bytes + 5 + 32 when done never comes. The error and idle results are sampled after a settling margin of many cycles, and a fixed extra wait then shows that no further edges appear.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_WINIT, ST_DUMMY,
        ST_DATA, ST_TRAIL, ST_WDONE, ST_FIN
    } ld_state_e;

    typedef struct packed {
        logic done;
        logic err_init;
        logic err_crc;
        logic err_done;
    } ld_flags_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[BYTE_W-1-i] = b[i];
        return r;
    endfunction

endpackage

// File: rtl/cfgld_clkgen.sv
module cfgld_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    input  logic go,
    output logic free,
    output logic cclk
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(CLK_DIV);

    logic          active;
    logic [CW-1:0] cnt;

    assign free = !active || (cnt == CW'(CLK_DIV - 1));
    assign cclk = active && (cnt >= CW'(HALF));

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (free) begin
            active <= go;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfgld_bytebuf.sv
module cfgld_bytebuf
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr,
    input  logic [BYTE_W-1:0] din,
    input  logic              rev,
    input  logic              last_in,
    input  logic              accept,
    input  logic              consume,
    output logic              full,
    output logic [BYTE_W-1:0] byte_o,
    output logic              last_o,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full    <= 1'b0;
            byte_o  <= '0;
            last_o  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (consume) full <= 1'b0;
            if (wr && accept) begin
                full   <= 1'b1;
                byte_o <= rev ? flip_byte(din) : din;
                last_o <= last_in;
            end else if (wr) begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int PROG_LOW     = 16,
    parameter int INIT_TIMEOUT = 256,
    parameter int TRAIL_CLKS   = 5,
    parameter int DONE_TIMEOUT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              init_n,
    input  logic              done_in,
    input  logic              free,
    input  logic              buf_full,
    input  logic [BYTE_W-1:0] buf_byte,
    input  logic              buf_last,
    output logic              go,
    output logic              consume,
    output logic              halt,
    output logic              prog_n,
    output logic              in_data,
    output logic              busy,
    output logic [BYTE_W-1:0] cdata,
    output ld_flags_t         flags
);
    localparam int MAXC = imax(imax(PROG_LOW, INIT_TIMEOUT), imax(TRAIL_CLKS, DONE_TIMEOUT));
    localparam int CW   = $clog2(MAXC + 1);

    ld_state_e     state;
    logic [CW-1:0] cnt;
    logic          loading;

    assign loading = (state == ST_DUMMY) || (state == ST_DATA) ||
                     (state == ST_TRAIL) || (state == ST_WDONE);
    assign halt    = !loading;
    assign prog_n  = (state != ST_PROG);
    assign in_data = (state == ST_DATA);
    assign busy    = (state != ST_IDLE) && (state != ST_FIN);

    always_comb begin
        go = 1'b0;
        if (free && init_n && !start) begin
            unique case (state)
                ST_DUMMY, ST_TRAIL: go = 1'b1;
                ST_DATA:            go = buf_full;
                ST_WDONE:           go = !done_in && (cnt != CW'(DONE_TIMEOUT));
                default:            go = 1'b0;
            endcase
        end
    end
    assign consume = go && (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state <= ST_PROG;
            cnt   <= '0;
            flags <= '0;
            cdata <= '1;
        end else if (loading && !init_n) begin
            state         <= ST_IDLE;
            flags.err_crc <= 1'b1;
        end else begin
            unique case (state)
                ST_PROG: begin
                    if (cnt == CW'(PROG_LOW - 1)) begin
                        state <= ST_WINIT;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_WINIT: begin
                    if (init_n) state <= ST_DUMMY;
                    else if (cnt == CW'(INIT_TIMEOUT - 1)) begin
                        state          <= ST_IDLE;
                        flags.err_init <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                ST_DUMMY: if (go) begin
                    cdata <= '1;
                    state <= ST_DATA;
                end
                ST_DATA: if (go) begin
                    cdata <= buf_byte;
                    if (buf_last) begin
                        state <= ST_TRAIL;
                        cnt   <= '0;
                    end
                end
                ST_TRAIL: if (go) begin
                    cdata <= '1;
                    if (cnt == CW'(TRAIL_CLKS - 1)) begin
                        state <= ST_WDONE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_WDONE: if (free) begin
                    if (done_in) begin
                        state      <= ST_FIN;
                        flags.done <= 1'b1;
                    end else if (cnt == CW'(DONE_TIMEOUT)) begin
                        state          <= ST_IDLE;
                        flags.err_done <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int PROG_LOW     = 16,
    parameter int INIT_TIMEOUT = 256,
    parameter int TRAIL_CLKS   = 5,
    parameter int DONE_TIMEOUT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_start,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    input  logic       host_rev,
    input  logic       host_last,
    output logic       stat_busy,
    output logic       stat_rdy,
    output logic       stat_done,
    output logic       stat_err_init,
    output logic       stat_err_crc,
    output logic       stat_err_done,
    output logic       stat_overrun,
    output logic       cfg_prog_n,
    input  logic       cfg_init_n,
    input  logic       cfg_done,
    output logic       cfg_cclk,
    output logic [7:0] cfg_data
);
    logic              go, consume, halt, free, in_data, buf_full, buf_last;
    logic [BYTE_W-1:0] buf_byte;
    ld_flags_t         flags;

    assign stat_rdy      = in_data && !buf_full;
    assign stat_done     = flags.done;
    assign stat_err_init = flags.err_init;
    assign stat_err_crc  = flags.err_crc;
    assign stat_err_done = flags.err_done;

    cfgld_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk(clk), .rst(rst), .halt(halt), .go(go), .free(free), .cclk(cfg_cclk)
    );

    cfgld_bytebuf u_buf (
        .clk(clk), .rst(rst), .clear(host_start), .wr(host_wr), .din(host_data),
        .rev(host_rev), .last_in(host_last), .accept(stat_rdy), .consume(consume),
        .full(buf_full), .byte_o(buf_byte), .last_o(buf_last), .overrun(stat_overrun)
    );

    cfgld_seq #(
        .PROG_LOW(PROG_LOW), .INIT_TIMEOUT(INIT_TIMEOUT),
        .TRAIL_CLKS(TRAIL_CLKS), .DONE_TIMEOUT(DONE_TIMEOUT)
    ) u_seq (
        .clk(clk), .rst(rst), .start(host_start), .init_n(cfg_init_n), .done_in(cfg_done),
        .free(free), .buf_full(buf_full), .buf_byte(buf_byte), .buf_last(buf_last),
        .go(go), .consume(consume), .halt(halt), .prog_n(cfg_prog_n), .in_data(in_data),
        .busy(stat_busy), .cdata(cfg_data), .flags(flags)
    );
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int PROG_LOW = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       stat_rdy,
    input logic       stat_busy,
    input logic       stat_done,
    input logic       stat_overrun,
    input logic       prog_n,
    input logic       done_in,
    input logic       cclk,
    input logic [7:0] cdata
);
    int low_run;

    always_ff @(posedge clk) begin
        if (rst) low_run <= 0;
        else if (!prog_n) low_run <= low_run + 1;
        else low_run <= 0;
    end

    p_prog_width_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_n) |-> (low_run == PROG_LOW));

    p_no_clk_in_prog_r2: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> !cclk);

    p_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $stable(cdata));

    p_overrun_r7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !stat_rdy) |=> stat_overrun);

    p_done_seen_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $past(done_in));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !stat_busy |=> !cclk);
endmodule

bind cfg_loader cfgld_checker #(.PROG_LOW(PROG_LOW)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .stat_rdy(stat_rdy), .stat_busy(stat_busy),
    .stat_done(stat_done), .stat_overrun(stat_overrun), .prog_n(cfg_prog_n),
    .done_in(cfg_done), .cclk(cfg_cclk), .cdata(cfg_data)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
    logic       clk = 0;
    logic       rst = 1;
    logic       host_start = 0, host_wr = 0, host_rev = 0, host_last = 0;
    logic [7:0] host_data = 0;
    logic       cfg_init_n = 0, cfg_done = 0;
    logic       stat_busy, stat_rdy, stat_done, stat_err_init, stat_err_crc;
    logic       stat_err_done, stat_overrun, cfg_prog_n, cfg_cclk;
    logic [7:0] cfg_data;

    int total = 0, bad = 0;
    int n_edges = 0, cyc = 0;
    logic [7:0] cap [0:255];
    int rt [0:255];
    logic prev_cclk = 0;
    logic done_force = 0;
    int   done_at = 0;

    always #5 clk = ~clk;

    cfg_loader dut (
        .clk(clk), .rst(rst), .host_start(host_start), .host_wr(host_wr),
        .host_data(host_data), .host_rev(host_rev), .host_last(host_last),
        .stat_busy(stat_busy), .stat_rdy(stat_rdy), .stat_done(stat_done),
        .stat_err_init(stat_err_init), .stat_err_crc(stat_err_crc),
        .stat_err_done(stat_err_done), .stat_overrun(stat_overrun),
        .cfg_prog_n(cfg_prog_n), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
        .cfg_cclk(cfg_cclk), .cfg_data(cfg_data)
    );

    // edge monitor: captures data at every configuration clock rise
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cfg_cclk && !prev_cclk && n_edges < 256) begin
            cap[n_edges] = cfg_data;
            rt[n_edges]  = cyc;
            n_edges = n_edges + 1;
        end
        prev_cclk = cfg_cclk;
        cfg_done = done_force || (done_at != 0 && n_edges >= done_at);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic rv, input logic lst);
        int lim = 0;
        while (!stat_rdy && lim < 500) begin @(negedge clk); lim++; end
        host_data = d; host_rev = rv; host_last = lst; host_wr = 1;
        @(negedge clk);
        host_wr = 0; host_last = 0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        int lim = 0;
        while (stat_busy && lim < 3000) begin @(negedge clk); lim++; end
    endtask

    task automatic pulse_start();
        host_start = 1;
        @(negedge clk);
        host_start = 0;
    endtask

    task automatic t_reset_and_prog();
        int cnt = 0;
        repeat (3) @(negedge clk);
        chk(!cfg_prog_n && !stat_rdy && !cfg_cclk, "R1 reset state", {cfg_prog_n, stat_rdy, cfg_cclk}, 0);
        rst = 0;
        while (!cfg_prog_n && cnt < 100) begin
            if (cnt == 3) begin
                chk(stat_busy, "R1 busy in prog", stat_busy, 1);
                host_data = 8'h5A; host_wr = 1;     // not ready: must be dropped
            end else host_wr = 0;
            cnt++;
            @(negedge clk);
        end
        host_wr = 0;
        chk(cnt == 16, "R1 prog low width", cnt, 16);
    endtask

    task automatic t_basic_load();
        int b = n_edges;
        done_force = 1;
        cfg_init_n = 1;
        wr_byte(8'hA5, 0, 0); wr_byte(8'h3C, 0, 0); wr_byte(8'h01, 0, 0); wr_byte(8'h80, 0, 1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(n_edges - b == 10, "R8 edge count", n_edges - b, 10);
        chk(cap[b] == 8'hFF, "R3 dummy byte first", cap[b], 8'hFF);
        chk(cap[b+1] == 8'hA5 && cap[b+2] == 8'h3C, "R5 order 1", {cap[b+1], cap[b+2]}, 16'hA53C);
        chk(cap[b+3] == 8'h01 && cap[b+4] == 8'h80, "R5 order 2 R6 no-rev", {cap[b+3], cap[b+4]}, 16'h0180);
        for (int k = 5; k < 10; k++) chk(cap[b+k] == 8'hFF, "R8 trailing ones", cap[b+k], 8'hFF);
        chk(rt[b+9] - rt[b+8] == 4, "R4 period", rt[b+9] - rt[b+8], 4);
        chk(stat_done && !stat_busy, "R9 done flag", {stat_done, stat_busy}, 2);
        chk(stat_overrun, "R7 overrun sticky", stat_overrun, 1);
        done_force = 0;
    endtask

    task automatic t_reverse_late_done();
        int b = n_edges;
        done_at = b + 11;
        cfg_init_n = 0;
        pulse_start();
        chk(!stat_done && !stat_overrun && !stat_err_crc, "R12 flags cleared",
            {stat_done, stat_overrun, stat_err_crc}, 0);
        while (!cfg_prog_n) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(n_edges == b && stat_busy, "R2 no clock before init", n_edges - b, 0);
        cfg_init_n = 1;
        wr_byte(8'h01, 1, 0); wr_byte(8'h12, 1, 1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(cap[b+1] == 8'h80, "R6 reversed 1", cap[b+1], 8'h80);
        chk(cap[b+2] == 8'h48, "R6 reversed 2", cap[b+2], 8'h48);
        chk(n_edges - b == 11, "R9 clocks until done", n_edges - b, 11);
        chk(stat_done && !stat_err_done, "R9 done late", {stat_done, stat_err_done}, 2);
        done_at = 0;
    endtask

    task automatic t_done_timeout();
        int b = n_edges;
        pulse_start();
        wr_byte(8'h77, 0, 1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(n_edges - b == 39, "R10 edges", n_edges - b, 39);
        chk(stat_err_done && !stat_done && !stat_busy, "R10 flag",
            {stat_err_done, stat_done, stat_busy}, 4);
    endtask

    task automatic t_abort();
        int b;
        pulse_start();
        wr_byte(8'h11, 0, 0); wr_byte(8'h22, 0, 0);
        cfg_init_n = 0;
        repeat (10) @(negedge clk);
        b = n_edges;
        chk(stat_err_crc && !stat_busy && !stat_rdy, "R11 abort flags",
            {stat_err_crc, stat_busy, stat_rdy}, 4);
        repeat (30) @(negedge clk);
        chk(n_edges == b && !cfg_cclk, "R11 clock stopped", n_edges - b, 0);
    endtask

    task automatic t_init_timeout();
        int b = n_edges;
        cfg_init_n = 0;
        pulse_start();
        repeat (300) @(negedge clk);
        chk(stat_err_init && !stat_busy, "R2 init timeout", {stat_err_init, stat_busy}, 2);
        chk(n_edges == b && !stat_err_crc, "R2 no edges", n_edges - b, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_and_prog();
        t_basic_load();
        t_reverse_late_done();
        t_done_timeout();
        t_abort();
        t_init_timeout();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule